// File: doc/BRIEF.md
# SMT Commit Thread Selector

On each commit slot of a simultaneous-multithreading core, this block decides which hardware thread may retire the instruction at the head of its reorder buffer. Each thread reports four things: its commit state, whether its reorder buffer is empty, whether its head entry is ready, and that head's sequence number. A policy input chooses how to arbitrate. Round-robin keeps a rotating priority order. Oldest-ready picks the thread whose head is oldest. A third, greedy policy code uses the oldest-ready choice and lets the consumer take several grants in a row.

The selection is presented as a stream: `sel_valid` with `sel_tid`. It is consumed when `sel_valid` and `sel_ready` are both high at a rising clock edge. `sel_valid`/`sel_tid` are a combinational function of the current inputs and the stored priority order. A consumer that holds `sel_ready` low sees the same offer for as long as the inputs stay the same, and nothing changes inside the block. Only a consumed round-robin grant updates the stored order. The logic that actually retires the instruction sits outside this block.

State codes (3 bits per thread, thread t at bits [3t+2:3t]) are: 0 idle, 1 running, 2 squashing, 3 trap wait, 4 fetch-trap wait, and 5 to 7 reserved. Policy codes are: 0 round-robin, 1 oldest-ready, 2 greedy, and 3 handled as oldest-ready.

Top module: `smt_commit_sel`

## Requirements
- R1: A thread can be selected only while its state code is 0 (idle), 1 (running) or 4 (fetch-trap wait). Codes 2, 3 and 5 to 7 exclude it.
- R2: With more than one thread, a thread qualifies only if it is eligible, its `rob_empty` bit is 0 and its `head_ready` bit is 1.
- R3: Under policy 0, the selected thread is the first qualifying thread in the stored priority order.
- R4: When a policy-0 grant is consumed, the granted thread moves to the last place in the priority order. The other threads keep their relative order.
- R5: The priority order does not change unless a grant is consumed (`sel_valid` and `sel_ready` high at a clock edge) while the policy is 0. A grant held without `sel_ready`, or consumed under another policy, leaves it unchanged.
- R6: Under policy 1, the selected thread is the qualifying thread with the smallest head sequence number (unsigned). On a tie, the lowest thread index wins.
- R7: Policy codes 2 and 3 select exactly as policy 1 does, and a grant can be consumed on every cycle.
- R8: When no thread qualifies, `sel_valid` is 0 and `sel_tid` is 0.
- R9: After reset the priority order is 0, 1, ..., NT-1. The first policy-0 grant therefore goes to the lowest qualifying index.
- R10: With NT = 1, `sel_valid` equals the eligibility of thread 0 under any policy, whatever `rob_empty` and `head_ready` show. `sel_tid` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Arbitration policy code |
| thr_status | input | 3*NT | Per-thread state code |
| rob_empty | input | NT | Per-thread reorder buffer empty |
| head_ready | input | NT | Per-thread head entry ready to retire |
| head_seq | input | SEQ_W*NT | Per-thread head sequence number |
| sel_valid | output | 1 | A thread is offered for retirement |
| sel_tid | output | TID_W | Index of the offered thread |
| sel_ready | input | 1 | Consumer takes the offer this cycle |

## Verification
The bench targets the round-robin order after a partial grant set. A design that appended the winner but shifted the wrong entries would reorder the remaining threads, and the third grant would go to the wrong thread. It holds a grant with `sel_ready` low and also consumes grants under the oldest policy. A block that rotated without a handshake, or under the wrong policy, would then show a changed round-robin winner. Oldest-ready is checked with equal sequence numbers, where a non-strict compare would hand the grant to the higher index. It also puts ineligible threads on the oldest heads, which a design that skipped the state filter would pick. A single-thread instance checks that empty and not-ready heads still produce a grant.

// File: rtl/smt_sel_pkg.sv
package smt_sel_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    TS_IDLE       = 3'd0,
    TS_RUN        = 3'd1,
    TS_SQUASH     = 3'd2,
    TS_TRAP_WAIT  = 3'd3,
    TS_FTRAP_WAIT = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_RR     = 2'd0,
    POL_OLDEST = 2'd1,
    POL_GREEDY = 2'd2,
    POL_SPARE  = 2'd3
  } pol_e;

  function automatic logic st_can_commit(input logic [ST_W-1:0] s);
    return (s == TS_IDLE) || (s == TS_RUN) || (s == TS_FTRAP_WAIT);
  endfunction

endpackage

// File: rtl/smt_qualify.sv
module smt_qualify
  import smt_sel_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [ST_W*NT-1:0] thr_status,
  input  logic [NT-1:0]      rob_empty,
  input  logic [NT-1:0]      head_ready,
  output logic [NT-1:0]      qual
);

  generate
    if (NT == 1) begin : g_single
      // A lone thread is offered on state alone.
      assign qual[0] = st_can_commit(thr_status[ST_W-1:0]);
    end else begin : g_multi
      for (genvar t = 0; t < NT; t++) begin : g_thr
        assign qual[t] = st_can_commit(thr_status[t*ST_W +: ST_W])
                         && !rob_empty[t] && head_ready[t];
      end
    end
  endgenerate

endmodule

// File: rtl/smt_rr_list.sv
module smt_rr_list #(
  parameter int NT    = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    qual,
  input  logic             advance,
  output logic             pick_valid,
  output logic [TID_W-1:0] pick_tid
);

  logic [TID_W-1:0] order_q [NT];
  logic [TID_W-1:0] order_d [NT];
  int               hit_pos;
  logic             hit;

  // First qualifying entry, scanning from the front of the list.
  always_comb begin
    hit     = 1'b0;
    hit_pos = 0;
    for (int p = 0; p < NT; p++) begin
      if (!hit && qual[order_q[p]]) begin
        hit     = 1'b1;
        hit_pos = p;
      end
    end
    pick_valid = hit;
    pick_tid   = hit ? order_q[hit_pos] : '0;
  end

  // Winner to the tail, the entries behind it close the gap.
  always_comb begin
    for (int p = 0; p < NT - 1; p++) begin
      order_d[p] = (p >= hit_pos) ? order_q[p+1] : order_q[p];
    end
    order_d[NT-1] = order_q[hit_pos];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NT; p++) order_q[p] <= TID_W'(p);
    end else if (advance && hit) begin
      for (int p = 0; p < NT; p++) order_q[p] <= order_d[p];
    end
  end

endmodule

// File: rtl/smt_oldest_pick.sv
module smt_oldest_pick #(
  parameter int NT    = 4,
  parameter int SEQ_W = 16,
  parameter int TID_W = 2
) (
  input  logic [NT-1:0]       qual,
  input  logic [SEQ_W*NT-1:0] head_seq,
  output logic                pick_valid,
  output logic [TID_W-1:0]    pick_tid
);

  logic [SEQ_W-1:0] best_seq;
  logic             found;

  // Strict less-than keeps the lower index on equal sequence numbers.
  always_comb begin
    found    = 1'b0;
    best_seq = '0;
    pick_tid = '0;
    for (int t = 0; t < NT; t++) begin
      if (qual[t] && (!found || head_seq[t*SEQ_W +: SEQ_W] < best_seq)) begin
        found    = 1'b1;
        best_seq = head_seq[t*SEQ_W +: SEQ_W];
        pick_tid = TID_W'(t);
      end
    end
    pick_valid = found;
  end

endmodule

// File: rtl/smt_commit_sel.sv
module smt_commit_sel
  import smt_sel_pkg::*;
#(
  parameter  int NT    = 4,
  parameter  int SEQ_W = 16,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          policy,
  input  logic [ST_W*NT-1:0]  thr_status,
  input  logic [NT-1:0]       rob_empty,
  input  logic [NT-1:0]       head_ready,
  input  logic [SEQ_W*NT-1:0] head_seq,
  output logic                sel_valid,
  output logic [TID_W-1:0]    sel_tid,
  input  logic                sel_ready
);

  logic [NT-1:0] qual;

  smt_qualify #(.NT(NT)) u_qual (
    .thr_status (thr_status),
    .rob_empty  (rob_empty),
    .head_ready (head_ready),
    .qual       (qual)
  );

  generate
    if (NT == 1) begin : g_one
      assign sel_valid = qual[0];
      assign sel_tid   = '0;
    end else begin : g_many
      logic             rr_valid, old_valid, rr_mode, rr_take;
      logic [TID_W-1:0] rr_tid, old_tid;

      assign rr_mode = (policy == POL_RR);
      assign rr_take = rr_mode && sel_ready;

      smt_rr_list #(.NT(NT), .TID_W(TID_W)) u_rr (
        .clk        (clk),
        .rst_n      (rst_n),
        .qual       (qual),
        .advance    (rr_take),
        .pick_valid (rr_valid),
        .pick_tid   (rr_tid)
      );

      smt_oldest_pick #(.NT(NT), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_old (
        .qual       (qual),
        .head_seq   (head_seq),
        .pick_valid (old_valid),
        .pick_tid   (old_tid)
      );

      assign sel_valid = rr_mode ? rr_valid : old_valid;
      assign sel_tid   = rr_mode ? rr_tid   : old_tid;
    end
  endgenerate

endmodule

// File: rtl/smt_commit_sel_chk.sv
module smt_commit_sel_chk
  import smt_sel_pkg::*;
#(
  parameter int NT    = 4,
  parameter int SEQ_W = 16,
  parameter int TID_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          policy,
  input logic [ST_W*NT-1:0]  thr_status,
  input logic [NT-1:0]       rob_empty,
  input logic [NT-1:0]       head_ready,
  input logic [SEQ_W*NT-1:0] head_seq,
  input logic                sel_valid,
  input logic [TID_W-1:0]    sel_tid,
  input logic                sel_ready
);

  logic [NT-1:0] ok_thr;
  logic          any_ok, older_seen, win_elig, win_head;

  always_comb begin
    older_seen = 1'b0;
    for (int t = 0; t < NT; t++) begin
      ok_thr[t] = st_can_commit(thr_status[t*ST_W +: ST_W])
                  && ((NT == 1) || (!rob_empty[t] && head_ready[t]));
      if (ok_thr[t] && head_seq[t*SEQ_W +: SEQ_W] < head_seq[sel_tid*SEQ_W +: SEQ_W])
        older_seen = 1'b1;
    end
    any_ok   = |ok_thr;
    win_elig = st_can_commit(thr_status[sel_tid*ST_W +: ST_W]);
    win_head = !rob_empty[sel_tid] && head_ready[sel_tid];
  end

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> win_elig); // R1

  AST_WIN_HEAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && NT > 1) |-> win_head); // R2

  AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && policy != POL_RR) |-> !older_seen); // R6

  AST_NONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ok |-> !sel_valid); // R8

  AST_IDLE_TID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_tid == '0)); // R8

  AST_HOLD_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_RR && sel_valid && !sel_ready) |=>
    (!($stable(thr_status) && $stable(rob_empty) && $stable(head_ready)
       && $stable(policy)) || sel_tid == $past(sel_tid))); // R5

endmodule

bind smt_commit_sel smt_commit_sel_chk #(
  .NT(NT), .SEQ_W(SEQ_W), .TID_W(TID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .policy     (policy),
  .thr_status (thr_status),
  .rob_empty  (rob_empty),
  .head_ready (head_ready),
  .head_seq   (head_seq),
  .sel_valid  (sel_valid),
  .sel_tid    (sel_tid),
  .sel_ready  (sel_ready)
);

// File: tb/smt_commit_sel_bench.sv
module smt_commit_sel_bench;

  localparam int NT    = 4;
  localparam int SEQ_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        policy = 2'd0;
  logic [2:0]        st [NT];
  logic [NT-1:0]     rob_empty = '1;
  logic [NT-1:0]     head_ready = '0;
  logic [SEQ_W-1:0]  seq [NT];
  logic [3*NT-1:0]   thr_status;
  logic [SEQ_W*NT-1:0] head_seq;
  logic              sel_valid, sel_ready = 1'b0;
  logic [1:0]        sel_tid;

  logic [2:0]        one_st = 3'd0;
  logic              one_empty = 1'b1, one_ready = 1'b0, one_valid;
  logic [0:0]        one_tid;
  logic [1:0]        one_pol = 2'd0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      thr_status[t*3 +: 3]     = st[t];
      head_seq[t*SEQ_W +: SEQ_W] = seq[t];
    end
  end

  smt_commit_sel #(.NT(NT), .SEQ_W(SEQ_W)) u_smt_commit_sel (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(thr_status),
    .rob_empty(rob_empty), .head_ready(head_ready), .head_seq(head_seq),
    .sel_valid(sel_valid), .sel_tid(sel_tid), .sel_ready(sel_ready)
  );

  smt_commit_sel #(.NT(1), .SEQ_W(SEQ_W)) u_smt_commit_sel_one (
    .clk(clk), .rst_n(rst_n), .policy(one_pol), .thr_status(one_st),
    .rob_empty(one_empty), .head_ready(one_ready), .head_seq(16'd7),
    .sel_valid(one_valid), .sel_tid(one_tid), .sel_ready(1'b1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Settle inputs mid-cycle, then look.
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic all_ready(input logic [2:0] s);
    for (int t = 0; t < NT; t++) begin
      st[t] = s; seq[t] = SEQ_W'(100 + t);
    end
    rob_empty = '0; head_ready = '1;
  endtask

  task automatic do_reset();
    sel_ready = 1'b0; policy = 2'd0;
    for (int t = 0; t < NT; t++) begin st[t] = 3'd0; seq[t] = '0; end
    rob_empty = '1; head_ready = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // Offer check then one consumed grant.
  task automatic take(input string req, input int exp);
    settle();
    chk(req, sel_valid, 1);
    chk(req, sel_tid, exp);
    sel_ready = 1'b1;
    @(posedge clk);
    #1 sel_ready = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    settle();
    chk("R8 reset valid", sel_valid, 0);
    chk("R8 reset tid", sel_tid, 0);
  endtask

  task automatic t_rr_order();
    do_reset();
    all_ready(3'd1);
    settle();
    chk("R9 first pick", sel_tid, 0);
    repeat (2) @(posedge clk);
    settle();
    chk("R5 held offer", sel_tid, 0);
    take("R4 rotate", 0);
    take("R4 rotate", 1);
    take("R4 rotate", 2);
    take("R4 rotate", 3);
    take("R3 wrap", 0);
    // order now 1,2,3,0; qualify only 3 and 0
    head_ready = 4'b1001;
    take("R3 partial", 3);
    // order 1,2,0,3
    head_ready = 4'b1111;
    take("R4 keep rel order", 1);
    take("R4 keep rel order", 2);
    take("R4 keep rel order", 0);
  endtask

  task automatic t_no_rotate_other_policy();
    do_reset();
    all_ready(3'd0);
    policy = 2'd1;
    take("R5 oldest consume", 0);
    take("R5 oldest consume", 0);
    policy = 2'd0;
    head_ready = 4'b1110;
    take("R5 rr after oldest", 1);
    head_ready = 4'b1111;
    take("R5 list untouched", 0);
  endtask

  task automatic t_state_filter();
    do_reset();
    all_ready(3'd1);
    policy = 2'd1;
    st[0] = 3'd2; st[1] = 3'd3; st[2] = 3'd5; st[3] = 3'd4;
    seq[0] = 16'd1; seq[1] = 16'd2; seq[2] = 16'd3; seq[3] = 16'd90;
    settle();
    chk("R1 fetch-trap wait only", sel_tid, 3);
    st[2] = 3'd0;
    settle();
    chk("R1 idle eligible", sel_tid, 2);
    st[3] = 3'd7; st[2] = 3'd6;
    settle();
    chk("R8 none eligible valid", sel_valid, 0);
    chk("R8 none eligible tid", sel_tid, 0);
  endtask

  task automatic t_head_gating();
    do_reset();
    all_ready(3'd1);
    policy = 2'd1;
    seq[0] = 16'd5; seq[1] = 16'd6; seq[2] = 16'd50; seq[3] = 16'd40;
    rob_empty = 4'b0001; head_ready = 4'b1101;
    settle();
    chk("R2 empty and unready skipped", sel_tid, 3);
    head_ready = 4'b0000;
    settle();
    chk("R8 nothing ready", sel_valid, 0);
  endtask

  task automatic t_oldest();
    do_reset();
    all_ready(3'd1);
    policy = 2'd1;
    seq[0] = 16'd40; seq[1] = 16'd12; seq[2] = 16'd30; seq[3] = 16'd12;
    settle();
    chk("R6 tie lowest index", sel_tid, 1);
    seq[3] = 16'd11;
    settle();
    chk("R6 smallest seq", sel_tid, 3);
    policy = 2'd2;
    take("R7 greedy repeat", 3);
    take("R7 greedy repeat", 3);
    policy = 2'd3;
    settle();
    chk("R7 code 3", sel_tid, 3);
  endtask

  task automatic t_single();
    one_st = 3'd1; one_empty = 1'b1; one_ready = 1'b0; one_pol = 2'd0;
    settle();
    chk("R10 empty still offered", one_valid, 1);
    chk("R10 tid", one_tid, 0);
    one_pol = 2'd1;
    settle();
    chk("R10 other policy", one_valid, 1);
    one_st = 3'd3;
    settle();
    chk("R10 trap wait blocks", one_valid, 0);
  endtask

  initial begin
    t_reset_state();
    t_rr_order();
    t_no_rotate_other_policy();
    t_state_filter();
    t_head_gating();
    t_oldest();
    t_single();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule